// File: doc/BRIEF.md
# Latched Maskable Interrupt Aggregator

This block gathers edge events from a bank of slow status inputs of a power-management device and turns them into one active-low interrupt request for a host processor. Every status input feeds two interrupt sources: one for its rising edge and one for its falling edge. Each source owns a sticky latch bit and a mask bit. The bits are packed eight to a register group. The interrupt line is pulled low while any latched source is also unmasked.

The host reaches the block through a plain register port made of an address, write data, a write strobe and combinational read data. Each group has five addresses. Two of them are readable views: the latch view and the mask view. The other three take write-one commands: mask-set, mask-clear and latch-clear. The mask is never written as a whole word. This lets a host enable or disable a single source without a read-modify-write. After it services a set of events, the host writes those same bits to the latch-clear address.

Top module: `pm_irq_hub`

## Requirements
- R1: After reset every latch bit reads 0, every mask bit reads 1 (all sources disabled), and irqN is 1.
- R2: Status input k drives two sources: number 2k on its rising edge and number 2k+1 on its falling edge. Source n appears in group n/8 (integer division), at bit 7-(n mod 8) of that group, so the lowest number in a group sits in bit 7.
- R3: An edge on a status input passes through a two-flop synchronizer and then sets its latch bit. The bit is readable four clock cycles after the input changes and stays set until cleared.
- R4: Writing to the mask-set address of group g (default address 0x30+g) sets the mask bits written as 1 and leaves the bits written as 0 unchanged.
- R5: Writing to the mask-clear address of group g (default address 0x40+g) clears the mask bits written as 1 and leaves the bits written as 0 unchanged.
- R6: Writing to the latch-clear address of group g (default address 0x50+g) clears only the latch bits written as 1. Every other latched bit is kept. A latch bit falls only through such a write.
- R7: If an edge event reaches a latch bit in the same cycle as a latch-clear write to that bit, the event wins and the bit stays 1.
- R8: irqN is registered. It is 0 one cycle after some latch bit is 1 while its mask bit is 0, and it returns to 1 one cycle after no such bit remains.
- R9: Writes to the latch view (default 0x10+g) and the mask view (default 0x20+g) change nothing. Reads from any address other than those two views return 0.
- R10: A status input held at a constant level raises no further events once its edge has been latched and cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusIn | input | GROUPS*4 | Asynchronous status levels, one per pair of sources |
| regAddr | input | ADDR_W | Register address |
| regWe | input | 1 | Write strobe, one write per cycle |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bound checker watches the following on every cycle:
- the write-one effects of the mask-set and mask-clear addresses;
- that a latch bit can fall only after a latch-clear write to its group;
- that an event in flight always leaves its latch bit set;
- that writes to the read-only views leave the masks untouched;
- that irqN follows the pending state with one cycle of delay.

Only the bench scenarios can show the reversed bit placement and the pairing of rising and falling sources for every status input. The same holds for the four-cycle latency from the input, the absence of a second event while a level is held, and the exact cycle at which a clear and a new edge collide.

// File: rtl/pmirq_pkg.sv
package pmirq_pkg;
  localparam int REG_W  = 8;
  localparam int GIDX_W = 4;   // up to 16 register groups

  typedef enum logic [2:0] {
    KIND_NONE, KIND_LATCH, KIND_MASK, KIND_SETM, KIND_CLRM, KIND_CLRL
  } regKind_t;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic              setMask;
    logic              clrMask;
    logic              clrLatch;
    logic [GIDX_W-1:0] grp;
    logic [REG_W-1:0]  data;
  } wrStrobe_t;
endpackage

// File: rtl/pmirq_edge.sv
module pmirq_edge #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] statusIn,
  output logic [WIDTH-1:0] riseEvt,
  output logic [WIDTH-1:0] fallEvt
);
  // pipe[0..SYNC_STAGES-1] synchronize, pipe[SYNC_STAGES] holds history
  localparam int LAST = SYNC_STAGES;
  logic [WIDTH-1:0] pipe [LAST+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= statusIn;
  end

  for (genvar s = 1; s <= LAST; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign riseEvt = pipe[LAST-1] & ~pipe[LAST];
  assign fallEvt = ~pipe[LAST-1] & pipe[LAST];
endmodule

// File: rtl/pmirq_ctrl.sv
module pmirq_ctrl import pmirq_pkg::*; #(
  parameter int GROUPS      = 4,
  parameter int ADDR_W      = 8,
  parameter int LATCH_BASE  = 'h10,
  parameter int MASK_BASE   = 'h20,
  parameter int SETM_BASE   = 'h30,
  parameter int CLRM_BASE   = 'h40,
  parameter int CLRL_BASE   = 'h50
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  output wrStrobe_t         strb,
  output regKind_t          kind,
  output logic [GIDX_W-1:0] grp
);
  always_comb begin
    kind = KIND_NONE;
    grp  = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (regAddr == ADDR_W'(LATCH_BASE + g)) begin kind = KIND_LATCH; grp = GIDX_W'(g); end
      if (regAddr == ADDR_W'(MASK_BASE + g))  begin kind = KIND_MASK;  grp = GIDX_W'(g); end
      if (regAddr == ADDR_W'(SETM_BASE + g))  begin kind = KIND_SETM;  grp = GIDX_W'(g); end
      if (regAddr == ADDR_W'(CLRM_BASE + g))  begin kind = KIND_CLRM;  grp = GIDX_W'(g); end
      if (regAddr == ADDR_W'(CLRL_BASE + g))  begin kind = KIND_CLRL;  grp = GIDX_W'(g); end
    end
  end

  always_comb begin
    strb.setMask  = regWe && (kind == KIND_SETM);
    strb.clrMask  = regWe && (kind == KIND_CLRM);
    strb.clrLatch = regWe && (kind == KIND_CLRL);
    strb.grp      = grp;
    strb.data     = regWdata;
  end
endmodule

// File: rtl/pmirq_regs.sv
module pmirq_regs import pmirq_pkg::*; #(
  parameter int GROUPS = 4,
  localparam int NSRC  = GROUPS * REG_W,
  localparam int NSTAT = NSRC / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSTAT-1:0]  riseEvt,
  input  logic [NSTAT-1:0]  fallEvt,
  input  wrStrobe_t         strb,
  input  regKind_t          kind,
  input  logic [GIDX_W-1:0] grp,
  output logic [REG_W-1:0]  regRdata,
  output logic              irqN,
  output logic [NSRC-1:0]   latchVec,
  output logic [NSRC-1:0]   maskVec,
  output logic [NSRC-1:0]   evtVec
);
  logic [REG_W-1:0] latchArr [GROUPS];
  logic [REG_W-1:0] maskArr  [GROUPS];

  // source number -> register bit (reversed inside each group)
  for (genvar n = 0; n < NSRC; n++) begin : g_map
    localparam int POS = (n / REG_W) * REG_W + (REG_W - 1 - (n % REG_W));
    if (n % 2 == 0) begin : g_rise
      assign evtVec[POS] = riseEvt[n/2];
    end else begin : g_fall
      assign evtVec[POS] = fallEvt[n/2];
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic             hit;
    logic [REG_W-1:0] clrBits, nextLatch, nextMask;

    assign hit = (strb.grp == GIDX_W'(g));

    always_comb begin
      clrBits   = (hit && strb.clrLatch) ? strb.data : '0;
      // a fresh event overrides a simultaneous clear
      nextLatch = (latchArr[g] & ~clrBits) | evtVec[g*REG_W +: REG_W];
      nextMask  = maskArr[g];
      if (hit && strb.setMask) nextMask = nextMask | strb.data;
      if (hit && strb.clrMask) nextMask = nextMask & ~strb.data;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchArr[g] <= '0;
        maskArr[g]  <= '1;
      end else begin
        latchArr[g] <= nextLatch;
        maskArr[g]  <= nextMask;
      end
    end

    assign latchVec[g*REG_W +: REG_W] = latchArr[g];
    assign maskVec[g*REG_W +: REG_W]  = maskArr[g];
  end

  always_comb begin
    regRdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp == GIDX_W'(g)) begin
        if (kind == KIND_LATCH) regRdata = latchArr[g];
        if (kind == KIND_MASK)  regRdata = maskArr[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= ~|(latchVec & ~maskVec);
  end
endmodule

// File: rtl/pm_irq_hub.sv
module pm_irq_hub import pmirq_pkg::*; #(
  parameter int GROUPS      = 4,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LATCH_BASE  = 'h10,
  parameter int MASK_BASE   = 'h20,
  parameter int SETM_BASE   = 'h30,
  parameter int CLRM_BASE   = 'h40,
  parameter int CLRL_BASE   = 'h50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [GROUPS*4-1:0]   statusIn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWe,
  input  logic [7:0]            regWdata,
  output logic [7:0]            regRdata,
  output logic                  irqN
);
  localparam int NSRC  = GROUPS * REG_W;
  localparam int NSTAT = NSRC / 2;

  logic [NSTAT-1:0]  riseEvt, fallEvt;
  wrStrobe_t         strb;
  regKind_t          kind;
  logic [GIDX_W-1:0] grp;
  logic [NSRC-1:0]   latchVec, maskVec, evtVec;

  pmirq_edge #(.WIDTH(NSTAT), .SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rstN(rstN), .statusIn(statusIn),
    .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  pmirq_ctrl #(
    .GROUPS(GROUPS), .ADDR_W(ADDR_W), .LATCH_BASE(LATCH_BASE),
    .MASK_BASE(MASK_BASE), .SETM_BASE(SETM_BASE),
    .CLRM_BASE(CLRM_BASE), .CLRL_BASE(CLRL_BASE)
  ) ctrl_i (
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .strb(strb), .kind(kind), .grp(grp)
  );

  pmirq_regs #(.GROUPS(GROUPS)) regs_i (
    .clk(clk), .rstN(rstN), .riseEvt(riseEvt), .fallEvt(fallEvt),
    .strb(strb), .kind(kind), .grp(grp), .regRdata(regRdata),
    .irqN(irqN), .latchVec(latchVec), .maskVec(maskVec), .evtVec(evtVec)
  );
endmodule

// File: rtl/pmirq_chk.sv
module pmirq_chk #(
  parameter int GROUPS     = 4,
  parameter int ADDR_W     = 8,
  parameter int LATCH_BASE = 'h10,
  parameter int MASK_BASE  = 'h20,
  parameter int SETM_BASE  = 'h30,
  parameter int CLRM_BASE  = 'h40,
  parameter int CLRL_BASE  = 'h50,
  localparam int NSRC      = GROUPS * 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [7:0]        regWdata,
  input logic              irqN,
  input logic [NSRC-1:0]   latchVec,
  input logic [NSRC-1:0]   maskVec,
  input logic [NSRC-1:0]   evtVec
);
  logic pend;
  assign pend = |(latchVec & ~maskVec);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (latchVec == '0) && (maskVec == '1) && irqN);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> (($past(evtVec) & ~latchVec) == '0));

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend && $past(pend)) |-> !irqN);

  // R8
  irq_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pend && !$past(pend)) |-> irqN);

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWe && regAddr == ADDR_W'(SETM_BASE + g)) |=>
        ((maskVec[g*8 +: 8] & $past(regWdata)) == $past(regWdata)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWe && regAddr == ADDR_W'(CLRM_BASE + g)) |=>
        ((maskVec[g*8 +: 8] & $past(regWdata)) == 8'h00));

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWe && (regAddr == ADDR_W'(LATCH_BASE + g) || regAddr == ADDR_W'(MASK_BASE + g)))
        |=> $stable(maskVec));

    // R6
    latch_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
      (|($past(latchVec[g*8 +: 8]) & ~latchVec[g*8 +: 8])) |->
        $past(regWe && regAddr == ADDR_W'(CLRL_BASE + g)));
  end
endmodule

bind pm_irq_hub pmirq_chk #(
  .GROUPS(GROUPS), .ADDR_W(ADDR_W), .LATCH_BASE(LATCH_BASE),
  .MASK_BASE(MASK_BASE), .SETM_BASE(SETM_BASE),
  .CLRM_BASE(CLRM_BASE), .CLRL_BASE(CLRL_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .irqN(irqN), .latchVec(latchVec),
  .maskVec(maskVec), .evtVec(evtVec)
);

// File: tb/pm_irq_hub_tb_top.sv
module pm_irq_hub_tb_top;
  localparam int GROUPS = 2;
  localparam int NSTAT  = GROUPS * 4;
  localparam int LATB = 'h10, MASKB = 'h20, SETB = 'h30, CLRMB = 'h40, CLRLB = 'h50;

  logic clk = 0, rstN = 0;
  logic [NSTAT-1:0] statusIn = '0;
  logic [7:0] regAddr = '0, regWdata = '0, regRdata;
  logic regWe = 0, irqN;
  int compared = 0, mismatched = 0;
  logic [15:0] expLat;
  logic [15:0] expMask;
  logic [7:0] rd;

  always #4 clk = ~clk;

  pm_irq_hub #(.GROUPS(GROUPS)) dut_i (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .irqN(irqN)
  );

  function automatic int pos(int n);
    return (n / 8) * 8 + 7 - (n % 8);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    regAddr = 8'(a); regWdata = 8'(d); regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic regRead(input int a, output logic [7:0] v);
    @(negedge clk);
    regAddr = 8'(a);
    #1 v = regRdata;
  endtask

  task automatic checkLatches(input string req);
    logic [7:0] v;
    for (int g = 0; g < GROUPS; g++) begin
      regRead(LATB + g, v);
      check(v == expLat[g*8 +: 8], req, v, expLat[g*8 +: 8]);
    end
  endtask

  task automatic checkMasks(input string req);
    logic [7:0] v;
    for (int g = 0; g < GROUPS; g++) begin
      regRead(MASKB + g, v);
      check(v == expMask[g*8 +: 8], req, v, expMask[g*8 +: 8]);
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1;
    // R1 reset state
    expLat = '0; expMask = '1;
    check(irqN == 1'b1, "R1 irqN", irqN, 1);
    checkLatches("R1 latch");
    checkMasks("R1 mask");

    // R9 writes to read-only views are ignored, other reads return 0
    regWrite(LATB, 'hFF);
    regWrite(MASKB + 1, 'h00);
    checkLatches("R9 latch view write");
    checkMasks("R9 mask view write");
    regRead('h00, rd);  check(rd == 0, "R9 unmapped read", rd, 0);
    regRead(SETB, rd);  check(rd == 0, "R9 set-mask read", rd, 0);

    // R2 R3 R10 R6 sweep over every status input, both edges
    for (int k = 0; k < NSTAT; k++) begin
      @(negedge clk) statusIn[k] = 1'b1;
      cyc(3);
      expLat = '0; expLat[pos(2*k)] = 1'b1;
      checkLatches("R2 R3 rising source");
      cyc(6);
      checkLatches("R10 held level");
      regWrite(CLRLB + pos(2*k) / 8, 1 << (pos(2*k) % 8));
      expLat = '0;
      cyc(4);
      checkLatches("R6 R10 cleared and quiet");
      @(negedge clk) statusIn[k] = 1'b0;
      cyc(3);
      expLat[pos(2*k+1)] = 1'b1;
      checkLatches("R2 R3 falling source");
      regWrite(CLRLB + pos(2*k+1) / 8, 1 << (pos(2*k+1) % 8));
      expLat = '0;
      checkLatches("R6 clear falling");
    end

    // R5 / R4 mask sweep
    for (int g = 0; g < GROUPS; g++) begin
      for (int b = 0; b < 8; b++) begin
        regWrite(CLRMB + g, 1 << b);
        expMask[g*8 + b] = 1'b0;
        checkMasks("R5 clear-mask bit");
      end
      regWrite(SETB + g, 0);
      checkMasks("R4 zero write no change");
      for (int b = 0; b < 8; b++) begin
        regWrite(SETB + g, 1 << b);
        expMask[g*8 + b] = 1'b1;
        checkMasks("R4 set-mask bit");
      end
    end

    // R6 partial clear keeps other bits
    @(negedge clk) begin statusIn[0] = 1'b1; statusIn[1] = 1'b1; end
    cyc(4);
    expLat = '0; expLat[pos(0)] = 1'b1; expLat[pos(2)] = 1'b1;
    checkLatches("R2 two sources");
    regWrite(CLRLB, 'h80);
    expLat[pos(0)] = 1'b0;
    checkLatches("R6 partial clear");

    // R8 irq timing, latch bit 5 of group 0 is set
    check(irqN == 1'b1, "R8 masked source", irqN, 1);
    regWrite(CLRMB, 'h20);
    check(irqN == 1'b1, "R8 one-cycle latency assert", irqN, 1);
    cyc(1);
    check(irqN == 1'b0, "R8 asserted", irqN, 0);
    regWrite(CLRLB, 'h20);
    check(irqN == 1'b0, "R8 one-cycle latency release", irqN, 0);
    cyc(1);
    check(irqN == 1'b1, "R8 released", irqN, 1);
    regWrite(SETB, 'h20);
    expLat = '0;

    // R7 collision of clear and new event on bit 7 of group 0
    @(negedge clk) statusIn[0] = 1'b0;
    cyc(4);
    expLat[pos(1)] = 1'b1;
    checkLatches("R2 falling before collision");
    @(negedge clk) statusIn[0] = 1'b1;
    cyc(2);
    regAddr = CLRLB; regWdata = 'hC0; regWe = 1;
    @(negedge clk) regWe = 0;
    expLat = '0; expLat[pos(0)] = 1'b1;
    checkLatches("R7 event wins over clear");
    check(irqN == 1'b1, "R8 masked after collision", irqN, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule